// File: doc/BRIEF.md
# Aging-Counter Eviction Victim Selector

This block picks which of N physical page frames to evict. It approximates least-recently-used order with a small aging register per frame. Each frame has a usage flag. A memory access to the frame sets the flag. A periodic tick pulse folds every flag into the top of its frame's age register as the register shifts right, and the flag then starts a new interval. A frame that was touched recently therefore holds a large value. A frame that has been idle fades towards zero.

The victim search runs on a valid/ready handshake. `req_ready` is high only while no search is running, and a request is taken on a cycle where both `req_valid` and `req_ready` are high. A search visits one frame per cycle. It ends with a one-cycle `done` pulse that carries the chosen frame and its age. The result has no back-pressure: the consumer must take it on the pulse. Ticks, accesses and refills are plain strobes and are always accepted. A refill that arrives during a search still takes effect, but the search may already have passed that frame.

Top module: `aging_victim_sel`

## Requirements
- R1: After reset every age register and usage flag is zero, `req_ready` is 1 and `done` is 0, so the first search returns frame 0 with age 0.
- R2: On a tick, each frame's age register shifts right by one bit, and its usage flag as it stood before the tick enters the most significant bit. Between ticks the age registers do not change, except on a refill.
- R3: The usage flags are cleared by each tick after they are folded in. Any number of accesses to a frame within one interval have the same effect as a single access.
- R4: A search returns, on `victim` and `victim_age`, the frame whose age register holds the smallest value and that value.
- R5: When several frames share the smallest age, the lowest frame index is returned.
- R6: An access to a frame in the same cycle as a tick sets that frame's usage flag for the new interval. It is not lost, and it does not reach the age bit written by that tick.
- R7: A refill strobe loads the frame's age register with only its most significant bit set and clears its usage flag. An access to the same frame in the same cycle leaves the flag set. A refill takes priority over a tick for that frame.
- R8: The cycle after a request is accepted, `req_ready` drops to 0. `done` rises for exactly one cycle, NUM_FRAMES clock edges after the accepting edge, and `req_ready` is 1 again in that cycle.
- R9: During a search no tick is applied. A tick that arrives during a search is held and applied on the clock edge that ends the `done` cycle, so the result reflects the ages present when the search began.
- R10: A frame that has not been accessed for CNT_W consecutive ticks reads age zero, and it cannot be told apart from a frame that has been idle for longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Aging interval pulse |
| acc_valid | input | 1 | Memory access strobe |
| acc_frame | input | IDX_W | Frame touched by the access |
| fill_valid | input | 1 | Frame refill strobe |
| fill_frame | input | IDX_W | Frame being refilled |
| req_valid | input | 1 | Victim search request |
| req_ready | output | 1 | High when a request can be accepted (no search running) |
| done | output | 1 | One-cycle pulse: search result valid |
| victim | output | IDX_W | Index of the chosen frame |
| victim_age | output | CNT_W | Age value of the chosen frame |

## Verification
The hardest case to reach is a tick that lands inside a running search. The tick must be held back, the search must report the ages that were present before the tick, and the held tick must then be applied exactly once after the result pulse. The stimulus reaches this case on purpose: it raises `tick` a few cycles into the search, both in a directed test and at random during the random phase. A follow-up search then confirms that the deferred shift took place. Ties and fully faded frames are reached by long runs without accesses. Same-cycle access and tick pairs are reached by a directed test, and they also come up through the random strobes.

// File: rtl/aging_pkg.sv
package aging_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_st_e;
endpackage

// File: rtl/aging_slot.sv
module aging_slot #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             acc_hit,
  input  logic             fill_hit,
  output logic [CNT_W-1:0] age,
  output logic             used
);
  localparam logic [CNT_W-1:0] FRESH = {1'b1, {(CNT_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age  <= '0;
      used <= 1'b0;
    end else if (fill_hit) begin
      age  <= FRESH;
      used <= acc_hit;
    end else if (tick_en) begin
      age  <= {used, age[CNT_W-1:1]};
      used <= acc_hit;
    end else if (acc_hit) begin
      used <= 1'b1;
    end
  end

  // R2: ages move only on tick or refill
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !fill_hit) |=> $stable(age));
  // R2: the flag from before the tick lands in the top bit
  assert_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !fill_hit) |=> (age[CNT_W-1] == $past(used)));
  // R3: a set flag stays set until a tick or refill
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !fill_hit && used) |=> used);
  // R7: refill leaves the top bit set
  assert_fresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_hit |=> age[CNT_W-1]);
endmodule

// File: rtl/aging_min_scan.sv
module aging_min_scan
  import aging_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int CNT_W      = 8,
  parameter int IDX_W      = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [NUM_FRAMES-1:0][CNT_W-1:0] ages,
  output logic                             busy,
  output logic                             done,
  output logic [IDX_W-1:0]                 victim,
  output logic [CNT_W-1:0]                 victim_age
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  scan_st_e         st;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] best_val;
  logic [IDX_W-1:0] best_idx;
  logic [CNT_W-1:0] cur;
  logic             better;

  always_comb begin
    cur    = ages[idx];
    better = (cur < best_val);
  end

  assign busy = (st == SCAN_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= SCAN_IDLE;
      idx        <= '0;
      best_val   <= '1;
      best_idx   <= '0;
      done       <= 1'b0;
      victim     <= '0;
      victim_age <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        SCAN_IDLE: begin
          if (start) begin
            st       <= SCAN_RUN;
            idx      <= '0;
            best_val <= '1;
            best_idx <= '0;
          end
        end
        SCAN_RUN: begin
          if (better) begin
            best_val <= cur;
            best_idx <= idx;
          end
          if (idx == LAST) begin
            st         <= SCAN_IDLE;
            done       <= 1'b1;
            victim     <= better ? idx : best_idx;
            victim_age <= better ? cur : best_val;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        default: st <= SCAN_IDLE;
      endcase
    end
  end

  // R8: the result is a single-cycle pulse
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: an accepted request starts a search
  assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R8: the result follows a running search, and the block is idle again
  assert_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
endmodule

// File: rtl/aging_victim_sel.sv
module aging_victim_sel #(
  parameter int NUM_FRAMES = 8,
  parameter int CNT_W      = 8,
  localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_frame,
  input  logic             fill_valid,
  input  logic [IDX_W-1:0] fill_frame,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             done,
  output logic [IDX_W-1:0] victim,
  output logic [CNT_W-1:0] victim_age
);
  logic [NUM_FRAMES-1:0][CNT_W-1:0] ages;
  logic [NUM_FRAMES-1:0]            used;
  logic                             busy;
  logic                             tick_pend;
  logic                             tick_en;
  logic                             start;

  assign tick_en   = (tick | tick_pend) & ~busy;
  assign req_ready = ~busy;
  assign start     = req_valid & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n)             tick_pend <= 1'b0;
    else if (busy && tick)  tick_pend <= 1'b1;
    else if (!busy)         tick_pend <= 1'b0;
  end

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_slot
    aging_slot #(.CNT_W(CNT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .acc_hit  (acc_valid && (acc_frame == IDX_W'(g))),
      .fill_hit (fill_valid && (fill_frame == IDX_W'(g))),
      .age      (ages[g]),
      .used     (used[g])
    );
  end

  aging_min_scan #(
    .NUM_FRAMES (NUM_FRAMES),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W)
  ) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ages       (ages),
    .busy       (busy),
    .done       (done),
    .victim     (victim),
    .victim_age (victim_age)
  );

  // R9: ages are frozen while a search runs, unless a refill arrives
  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fill_valid) |=> $stable(ages));
  // R9: a tick during a search is remembered
  assert_hold_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick) |=> tick_pend);
  // R9: a held tick is used once the search ends
  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_pend && !busy) |=> !tick_pend);
endmodule

// File: tb/aging_victim_sel_test.sv
module aging_victim_sel_test;
  localparam int N = 8;
  localparam int W = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, acc_valid = 1'b0, fill_valid = 1'b0, req_valid = 1'b0;
  logic [IW-1:0] acc_frame = '0, fill_frame = '0;
  logic req_ready, done;
  logic [IW-1:0] victim;
  logic [W-1:0] victim_age;

  int n_run = 0;
  int n_fail = 0;
  int mcnt [N];
  bit mref [N];

  always #5 clk = ~clk;

  aging_victim_sel #(.NUM_FRAMES(N), .CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .acc_valid(acc_valid),
    .acc_frame(acc_frame), .fill_valid(fill_valid), .fill_frame(fill_frame),
    .req_valid(req_valid), .req_ready(req_ready), .done(done),
    .victim(victim), .victim_age(victim_age));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_min();
    int b = 0;
    for (int f = 1; f < N; f++) if (mcnt[f] < mcnt[b]) b = f;
    return b;
  endfunction

  function automatic void model_edge(bit tk, bit av, int af, bit fv, int ff);
    for (int f = 0; f < N; f++) begin
      bit a = av && (af == f);
      if (fv && ff == f) begin
        mcnt[f] = 1 << (W-1); mref[f] = a;
      end else if (tk) begin
        mcnt[f] = (int'(mref[f]) << (W-1)) | (mcnt[f] >> 1); mref[f] = a;
      end else if (a) mref[f] = 1'b1;
    end
  endfunction

  task automatic step(input bit tk, input bit av, input int af, input bit fv, input int ff);
    @(negedge clk);
    tick = tk; acc_valid = av; acc_frame = IW'(af); fill_valid = fv; fill_frame = IW'(ff);
    @(posedge clk);
    model_edge(tk, av, af, fv, ff);
  endtask

  task automatic query(input string tag, input bit tick_mid);
    int k, eb, ea;
    @(negedge clk);
    tick = 0; acc_valid = 0; fill_valid = 0;
    check(req_ready == 1'b1, {tag, " R8 ready idle"}, req_ready, 1);
    eb = model_min(); ea = mcnt[eb];
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, {tag, " R8 ready busy"}, req_ready, 0);
    k = 0;
    while (!done && k < 50) begin
      tick = tick_mid && (k == 2);
      @(posedge clk);
      k++;
      @(negedge clk);
    end
    tick = 1'b0;
    check(k == N, {tag, " R8 latency"}, k, N);
    check(victim == IW'(eb), {tag, " R4/R5 victim"}, victim, eb);
    check(victim_age == W'(ea), {tag, " R4 age"}, victim_age, ea);
    check(req_ready == 1'b1, {tag, " R8 ready at done"}, req_ready, 1);
    @(posedge clk);
    if (tick_mid) model_edge(1, 0, 0, 0, 0); // R9 deferred tick lands here
    @(negedge clk);
    check(done == 1'b0, {tag, " R8 pulse"}, done, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int f = 0; f < N; f++) begin mcnt[f] = 0; mref[f] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(done == 1'b0, "R1 done", done, 0);
    query("R1 R5 reset tie", 0);

    // R3: repeated accesses in one interval count once
    for (int f = 1; f < N; f++) step(0, 1, f, 0, 0);
    step(0, 1, 3, 0, 0); step(0, 1, 3, 0, 0);
    step(1, 0, 0, 0, 0);
    query("R3 R4 fold", 0);
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    query("R2 R5 shift", 0);

    // R6: access coinciding with a tick
    step(1, 1, 2, 0, 0);
    step(1, 0, 0, 0, 0);
    query("R6 same cycle", 0);

    // R7: refill, with a same-cycle access and tick
    step(0, 0, 0, 1, 5);
    query("R7 refill", 0);
    step(1, 1, 6, 1, 6);
    query("R7 refill tick", 0);

    // R10: history runs out after W idle ticks
    for (int i = 0; i < W + 3; i++) step(1, 0, 0, 0, 0);
    check(mcnt[4] == 0, "R10 model", mcnt[4], 0);
    query("R10 faded", 0);

    // R9: tick during a search is deferred
    step(0, 1, 1, 0, 0);
    query("R9 mid tick", 1);
    query("R9 after tick", 0);

    // random phase
    for (int it = 0; it < 400; it++) begin
      bit tk = ($urandom % 5) == 0;
      bit av = ($urandom % 2) == 0;
      bit fv = ($urandom % 9) == 0;
      int af = $urandom % N;
      int ff = $urandom % N;
      step(tk, av, af, fv, ff);
      if ((it % 10) == 9) query("R4 R9 random", ($urandom % 4) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule